// File: doc/BRIEF.md
# NAND Bad-Block Table Scanner

This block runs once after reset and surveys every erase block of a raw NAND flash device attached through its multiplexed pin set: chip enable, command latch, address latch, write strobe, read strobe, a shared I/O bus and the ready/busy line. For each block it issues one page read for page 0 and one for page 1. Each read points at the first spare-area location of the page. The block fetches the single factory marker value there and records the block as bad when either page returns something other than the erased pattern. Physical block 0 is never read and is always recorded as good.

The result is a one-bit-per-block bitmap. Any agent can read it combinationally by block index, at any time. `scan_busy`, `scan_done` and `scan_err` report progress. If the device keeps ready/busy low longer than the limit on `busy_limit`, the scan is abandoned and `scan_err` is raised. The `BUS_W` parameter selects an 8-bit or 16-bit device. It sets the marker column and the width of the erased pattern.

The sequencer is one state machine. Its states are IDLE, WR_LO, WR_HI, WAIT_RB, RD_LO, RD_HI, DONE and FAULT. Reset enters IDLE. IDLE always moves to WR_LO. WR_LO always moves to WR_HI. WR_HI returns to WR_LO for the next bus cycle, or moves to WAIT_RB after the last cycle of the command. WAIT_RB moves to RD_LO once the device is ready, or to FAULT when the limit is reached. RD_LO always moves to RD_HI. RD_HI moves to WR_LO for the next page or block, or to DONE after page 1 of the last block. DONE and FAULT hold until reset.

Top module: `nand_bbt_scan`

## Requirements
- R1: While reset is asserted, chip enable, write strobe and read strobe are high (inactive), `scan_busy`, `scan_done` and `scan_err` are low, and every bitmap bit reads 0; a new reset clears a previous result.
- R2: After reset is released, the scan starts by itself, and `scan_busy` is high from the second cycle until the scan ends.
- R3: Every page read is seven write-strobe cycles, each latched by the rising edge of the write strobe. The first is a command cycle carrying 00h. Then come five address cycles: the two column bytes, then the three row bytes, low byte first, with row = block × PAGES_PER_BLOCK + page. The last is a command cycle carrying 30h. Command latch and address latch are never high together, and write and read strobes are never low together.
- R4: The column address is 2048 for an 8-bit device and 1024 for a 16-bit device.
- R5: After the 30h cycle, the block waits at least two cycles, then until ready/busy is high, before driving the read strobe low. The read strobe never falls while ready/busy is low. One value is read per page.
- R6: A block (other than block 0) is marked bad exactly when the page 0 or page 1 marker differs from all ones over the full bus width (FFh for x8, FFFFh for x16).
- R7: Block 0 is never addressed by a page read, and its bitmap bit always reads 0.
- R8: After page 1 of the last block, `scan_done` goes high and chip enable returns high. `scan_busy` drops, and the state holds until reset.
- R9: If ready/busy stays low for `busy_limit` cycles of waiting, the scan stops. `scan_err` goes high, `scan_done` stays low, `scan_busy` drops and chip enable returns high.
- R10: `map_bad` shows bitmap bit `map_idx` combinationally, where 1 means bad and 0 means good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts a scan |
| busy_limit | input | TO_W | Maximum wait cycles on ready/busy before abort |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | BUS_W | I/O bus value driven to the device |
| nand_io_oe | output | 1 | High while the block drives the I/O bus |
| nand_io_in | input | BUS_W | I/O bus value returned by the device |
| nand_rb | input | 1 | Ready/busy, high when ready |
| map_idx | input | BLK_BITS | Bitmap read index |
| map_bad | output | 1 | Bitmap bit at `map_idx` |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan completed |
| scan_err | output | 1 | Scan aborted on ready/busy timeout |

## Verification
The bench runs a 16-bit device model with a random marker table. Some markers differ from FFFFh only in the high byte (7FFFh, 00FFh). A design that compared only the low byte would therefore miss those bad blocks. Directed blocks are bad on page 1 only or on page 0 only, which catches a scanner that reads one page. Block 0 carries a bad marker to catch a scanner that reads or flags it. One run uses a very short busy time, which catches a design that samples ready/busy before the device has pulled it low. Another run has the device stay busy past the limit, which must end in an error with no done flag and no bitmap bits set.

// File: rtl/nand_bbt_pkg.sv
package nand_bbt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HI,
        S_WAIT_RB,
        S_RD_LO,
        S_RD_HI,
        S_DONE,
        S_FAULT
    } scan_state_t;

    localparam logic [7:0] OP_READ_SETUP = 8'h00;
    localparam logic [7:0] OP_READ_GO    = 8'h30;
    localparam logic [2:0] SEQ_LAST      = 3'd6;
    localparam int         WB_CYCLES     = 2;

endpackage

// File: rtl/nand_bbt_cycle_gen.sv
module nand_bbt_cycle_gen
    import nand_bbt_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int BLK_BITS  = 11,
    parameter int PAGE_BITS = 6
) (
    input  logic [2:0]          seq,
    input  logic [BLK_BITS-1:0] blk,
    input  logic                page_sel,
    output logic [BUS_W-1:0]    io_val,
    output logic                is_cmd,
    output logic                is_addr
);
    localparam logic [15:0] MARK_COL = (BUS_W == 16) ? 16'd1024 : 16'd2048;

    logic [23:0] row;
    logic [7:0]  byte_val;

    assign row = (24'(blk) << PAGE_BITS) | 24'(page_sel);

    always_comb begin
        is_cmd   = 1'b0;
        is_addr  = 1'b0;
        byte_val = 8'h00;
        unique case (seq)
            3'd0: begin is_cmd  = 1'b1; byte_val = OP_READ_SETUP;  end
            3'd1: begin is_addr = 1'b1; byte_val = MARK_COL[7:0];  end
            3'd2: begin is_addr = 1'b1; byte_val = MARK_COL[15:8]; end
            3'd3: begin is_addr = 1'b1; byte_val = row[7:0];       end
            3'd4: begin is_addr = 1'b1; byte_val = row[15:8];      end
            3'd5: begin is_addr = 1'b1; byte_val = row[23:16];     end
            3'd6: begin is_cmd  = 1'b1; byte_val = OP_READ_GO;     end
            default: begin byte_val = 8'h00; end
        endcase
    end

    assign io_val = BUS_W'(byte_val);

endmodule

// File: rtl/nand_bbt_busy_timer.sv
module nand_bbt_busy_timer
    import nand_bbt_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            rb,
    input  logic [TO_W-1:0] limit,
    output logic            ready_seen,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + TO_W'(1);
        end
    end

    assign ready_seen = run && rb && (cnt >= TO_W'(WB_CYCLES));
    assign expired    = run && !ready_seen && (cnt >= limit);

    // R9: an abort is only ever signalled while the device reports busy
    a_r9_expire_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && cnt >= TO_W'(WB_CYCLES)) |-> !rb);

endmodule

// File: rtl/nand_bbt_bitmap.sv
module nand_bbt_bitmap #(
    parameter int NUM_BLOCKS = 2048,
    parameter int BLK_BITS   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [BLK_BITS-1:0] set_idx,
    input  logic [BLK_BITS-1:0] rd_idx,
    output logic                rd_bit
);
    logic [NUM_BLOCKS-1:0] bits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (set_en) begin
            bits[set_idx] <= 1'b1;
        end
    end

    assign rd_bit = (32'(rd_idx) < NUM_BLOCKS) ? bits[rd_idx] : 1'b0;

    // R7: block 0 is never written as bad
    a_r7_block0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (set_idx != '0));

endmodule

// File: rtl/nand_bbt_scan.sv
module nand_bbt_scan
    import nand_bbt_pkg::*;
#(
    parameter int BUS_W           = 8,
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int TO_W            = 16,
    parameter int BLK_BITS        = $clog2(NUM_BLOCKS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TO_W-1:0]     busy_limit,
    output logic                nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [BUS_W-1:0]    nand_io_out,
    output logic                nand_io_oe,
    input  logic [BUS_W-1:0]    nand_io_in,
    input  logic                nand_rb,
    input  logic [BLK_BITS-1:0] map_idx,
    output logic                map_bad,
    output logic                scan_busy,
    output logic                scan_done,
    output logic                scan_err
);
    localparam int                PAGE_BITS = $clog2(PAGES_PER_BLOCK);
    localparam logic [BLK_BITS-1:0] LAST_BLK = BLK_BITS'(NUM_BLOCKS - 1);
    localparam logic [BUS_W-1:0]  ERASED   = {BUS_W{1'b1}};

    scan_state_t state_q, state_d;

    logic [BLK_BITS-1:0] blk_q;
    logic                page_q;
    logic [2:0]          seq_q;
    logic [BUS_W-1:0]    sample_q;

    logic [BUS_W-1:0] gen_io;
    logic             gen_cmd, gen_addr;
    logic             rb_ready, rb_expired;
    logic             mark_bad;

    nand_bbt_cycle_gen #(
        .BUS_W    (BUS_W),
        .BLK_BITS (BLK_BITS),
        .PAGE_BITS(PAGE_BITS)
    ) u_gen (
        .seq     (seq_q),
        .blk     (blk_q),
        .page_sel(page_q),
        .io_val  (gen_io),
        .is_cmd  (gen_cmd),
        .is_addr (gen_addr)
    );

    nand_bbt_busy_timer #(
        .TO_W(TO_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == S_WAIT_RB),
        .rb        (nand_rb),
        .limit     (busy_limit),
        .ready_seen(rb_ready),
        .expired   (rb_expired)
    );

    assign mark_bad = (state_q == S_RD_HI) && (sample_q != ERASED);

    nand_bbt_bitmap #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_BITS  (BLK_BITS)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (mark_bad),
        .set_idx(blk_q),
        .rd_idx (map_idx),
        .rd_bit (map_bad)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    state_d = S_WR_LO;
            S_WR_LO:   state_d = S_WR_HI;
            S_WR_HI:   state_d = (seq_q == SEQ_LAST) ? S_WAIT_RB : S_WR_LO;
            S_WAIT_RB: begin
                if (rb_ready)        state_d = S_RD_LO;
                else if (rb_expired) state_d = S_FAULT;
            end
            S_RD_LO:   state_d = S_RD_HI;
            S_RD_HI:   state_d = (page_q && blk_q == LAST_BLK) ? S_DONE : S_WR_LO;
            S_DONE:    state_d = S_DONE;
            S_FAULT:   state_d = S_FAULT;
            default:   state_d = S_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // scan position and captured marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q    <= BLK_BITS'(1);
            page_q   <= 1'b0;
            seq_q    <= 3'd0;
            sample_q <= ERASED;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    blk_q  <= BLK_BITS'(1);
                    page_q <= 1'b0;
                    seq_q  <= 3'd0;
                end
                S_WR_HI: begin
                    if (seq_q != SEQ_LAST) seq_q <= seq_q + 3'd1;
                end
                S_RD_LO: sample_q <= nand_io_in;
                S_RD_HI: begin
                    seq_q <= 3'd0;
                    if (!page_q) begin
                        page_q <= 1'b1;
                    end else begin
                        page_q <= 1'b0;
                        if (blk_q != LAST_BLK) blk_q <= blk_q + BLK_BITS'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        nand_ce_n   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_we_n   = 1'b1;
        nand_re_n   = 1'b1;
        nand_io_oe  = 1'b0;
        nand_io_out = '0;
        scan_busy   = 1'b0;
        scan_done   = 1'b0;
        scan_err    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_WR_LO, S_WR_HI: begin
                nand_ce_n   = 1'b0;
                nand_cle    = gen_cmd;
                nand_ale    = gen_addr;
                nand_we_n   = (state_q != S_WR_LO);
                nand_io_oe  = 1'b1;
                nand_io_out = gen_io;
                scan_busy   = 1'b1;
            end
            S_WAIT_RB, S_RD_HI: begin
                nand_ce_n = 1'b0;
                scan_busy = 1'b1;
            end
            S_RD_LO: begin
                nand_ce_n = 1'b0;
                nand_re_n = 1'b0;
                scan_busy = 1'b1;
            end
            S_DONE:  scan_done = 1'b1;
            S_FAULT: scan_err  = 1'b1;
            default: ;
        endcase
    end

    // R3: command and address latches are exclusive, strobes are exclusive
    a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    a_r3_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R5: read strobe falls only after the device reported ready
    a_r5_read_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(nand_rb));
    // R8: finished scan releases the device
    a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (nand_ce_n && !scan_busy && !scan_err && !nand_io_oe));
    // R9: an abort follows a cycle in which the device was busy
    a_r9_abort_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_err) |-> !$past(nand_rb));

endmodule

// File: tb/nand_bbt_scan_test.sv
`timescale 1ns/1ps
module nand_bbt_scan_test;
    localparam int TB_W  = 16;
    localparam int NB    = 32;
    localparam int PPB   = 64;
    localparam int TOW   = 16;
    localparam int BB    = $clog2(NB);
    localparam logic [TB_W-1:0] ALL1 = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TOW-1:0] busy_limit;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [TB_W-1:0] nand_io_out, nand_io_in;
    logic nand_rb;
    logic [BB-1:0] map_idx;
    logic map_bad, scan_busy, scan_done, scan_err;

    always #2.5 clk = ~clk;

    nand_bbt_scan #(
        .BUS_W(TB_W), .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .TO_W(TOW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .busy_limit(busy_limit),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb(nand_rb),
        .map_idx(map_idx), .map_bad(map_bad),
        .scan_busy(scan_busy), .scan_done(scan_done), .scan_err(scan_err)
    );

    // device model
    logic [TB_W-1:0] mk [NB][2];
    logic [7:0] adr [5];
    int ac, busy_left, busy_cfg;
    int proto_err, wrong_col, blk0_reads, pages_read;
    logic prev_we, prev_re;

    function automatic logic [TB_W-1:0] dev_value();
        int col, row, b, p;
        col = {adr[1], adr[0]};
        row = {adr[4], adr[3], adr[2]};
        b = row / PPB;
        p = row % PPB;
        if (col != 1024 || p > 1 || b >= NB) return 16'h5A5A;
        return mk[b][p];
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            ac = 0; busy_left = 0; nand_rb = 1'b1;
            prev_we = 1'b1; prev_re = 1'b1; nand_io_in = '0;
        end else begin
            if (!prev_re && 1'b0) proto_err++;
            if (prev_re && !nand_re_n && !nand_rb) proto_err++;
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) nand_rb = 1'b1;
            end
            if (!prev_we && nand_we_n) begin
                if (nand_cle && nand_ale) proto_err++;
                if (nand_ce_n) proto_err++;
                if (nand_cle) begin
                    if (nand_io_out == 16'h0000) ac = 0;
                    else if (nand_io_out == 16'h0030) begin
                        if (ac != 5) proto_err++;
                        pages_read++;
                        if ({adr[1], adr[0]} != 16'd1024) wrong_col++;
                        if (({adr[4], adr[3], adr[2]} / PPB) == 0) blk0_reads++;
                        busy_left = busy_cfg;
                        nand_rb = 1'b0;
                    end else proto_err++;
                end else if (nand_ale) begin
                    if (ac < 5) adr[ac] = nand_io_out[7:0];
                    else proto_err++;
                    ac++;
                end
            end
            nand_io_in = dev_value();
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    int checks = 0, errors = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bad(input int b);
        return (b != 0) && (mk[b][0] != ALL1 || mk[b][1] != ALL1);
    endfunction

    task automatic clear_counts();
        proto_err = 0; wrong_col = 0; blk0_reads = 0; pages_read = 0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_end();
        int n = 0;
        while (!scan_done && !scan_err && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_map(input string req, input bit use_table);
        for (int b = 0; b < NB; b++) begin
            map_idx = BB'(b);
            #0.1;
            chk(map_bad == (use_table ? exp_bad(b) : 1'b0), req, map_bad,
                use_table ? exp_bad(b) : 0);
        end
    endtask

    task automatic run_scan(input int busy, input int limit);
        busy_cfg = busy;
        busy_limit = TOW'(limit);
        clear_counts();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scan_busy == 1'b1, "R2 busy after start", scan_busy, 1);
        wait_end();
    endtask

    task automatic check_finished(input string tag);
        chk(scan_done == 1'b1, {"R8 done ", tag}, scan_done, 1);
        chk(scan_err == 1'b0 && scan_busy == 1'b0 && nand_ce_n == 1'b1,
            {"R8 idle ", tag}, {scan_err, scan_busy, nand_ce_n}, 1);
        chk(proto_err == 0, {"R3 R5 protocol ", tag}, proto_err, 0);
        chk(wrong_col == 0, {"R4 column ", tag}, wrong_col, 0);
        chk(blk0_reads == 0, {"R7 block0 reads ", tag}, blk0_reads, 0);
        chk(pages_read == 2 * (NB - 1), {"R3 page reads ", tag}, pages_read, 2 * (NB - 1));
    endtask

    initial begin
        int seed_dummy;
        logic [TB_W-1:0] badpat [5];
        badpat[0] = 16'h0000; badpat[1] = 16'h00FF; badpat[2] = 16'h7FFF;
        badpat[3] = 16'hFFFE; badpat[4] = 16'hFF00;
        seed_dummy = $urandom(20240611);
        map_idx = '0;
        busy_limit = TOW'(200);
        busy_cfg = 10;
        clear_counts();

        // R1 reset state
        apply_reset();
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 pins idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
        chk(!scan_busy && !scan_done && !scan_err, "R1 flags low", {scan_busy, scan_done, scan_err}, 0);

        // scan A: random table plus directed blocks
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < 2; p++)
                mk[b][p] = (($urandom % 4) == 0) ? badpat[$urandom % 5] : ALL1;
        mk[0][0] = 16'h0000;                      // R7 bad marker on block 0
        mk[1][0] = ALL1; mk[1][1] = 16'h7FFF;     // R6 page 1 only, high byte
        mk[2][0] = 16'h00FF; mk[2][1] = ALL1;     // R6 page 0 only
        mk[NB-1][0] = ALL1; mk[NB-1][1] = 16'hFFFE;
        mk[3][0] = ALL1; mk[3][1] = ALL1;
        run_scan(12, 200);
        check_finished("scanA");
        check_map("R6 R10 map scanA", 1'b1);
        map_idx = '0; #0.1;
        chk(map_bad == 1'b0, "R7 block0 good", map_bad, 0);
        repeat (5) @(negedge clk);
        chk(scan_done == 1'b1, "R8 done holds", scan_done, 1);

        // R1 reset clears the bitmap
        apply_reset();
        check_map("R1 map cleared", 1'b0);

        // scan B: all erased, very short busy time
        for (int b = 0; b < NB; b++) begin mk[b][0] = ALL1; mk[b][1] = ALL1; end
        run_scan(1, 200);
        check_finished("scanB");
        check_map("R6 map all good", 1'b1);

        // scan C: everything bad, busy close to the limit
        apply_reset();
        for (int b = 0; b < NB; b++) begin
            mk[b][0] = badpat[$urandom % 5];
            mk[b][1] = (b % 2 == 0) ? ALL1 : badpat[$urandom % 5];
        end
        run_scan(35, 40);
        check_finished("scanC");
        check_map("R6 map all bad", 1'b1);

        // scan D: device never becomes ready in time
        apply_reset();
        run_scan(600, 60);
        chk(scan_err == 1'b1, "R9 error raised", scan_err, 1);
        chk(scan_done == 1'b0 && scan_busy == 1'b0, "R9 not done not busy", {scan_done, scan_busy}, 0);
        chk(nand_ce_n == 1'b1 && nand_re_n == 1'b1, "R9 device released", {nand_ce_n, nand_re_n}, 3);
        chk(pages_read == 1, "R9 single command", pages_read, 1);
        check_map("R9 map untouched", 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule